// File: doc/BRIEF.md
# Per-Core Interprocessor Interrupt Register Bank

This block is the register bank through which one processor core receives interrupts from other cores. Other agents post requests by writing bit masks into a set register. The owning core acknowledges by writing to a clear register. An enable word selects which pending bits may raise the core's single level-sensitive interrupt line. Eight 32-bit mailbox words sit beside these registers. A sender uses them to leave a message for the core.

Accesses arrive on a simple 32-bit register port: one request per cycle, with a write flag, an address and write data. Only the low byte of the address is decoded, so the bank repeats through the wider address space. Read data returns one cycle after the request. A one-cycle error pulse reports any access to an undecoded offset, and any write to the read-only status word.

The interrupt line has its own update rule. It is re-evaluated only when the set or clear register is written, and each of those writes uses its own condition. Writing the enable word never moves the line by itself.

Top module: `ipi_core_regs`

## Requirements
- R1: A synchronous active-low reset clears the pending word, the enable word, all mailbox words, the interrupt line, the read-valid flag and the error pulse.
- R2: Only address bits [7:0] are decoded, so an access at 0x104 behaves exactly like one at 0x004.
- R3: A write to the set register (offset 0x08) ORs the data into the pending word. If the new pending word ANDed with enable is nonzero, the interrupt line goes high after that clock edge.
- R4: A set write that leaves (pending AND enable) at zero leaves the interrupt line unchanged.
- R5: A write to the clear register (offset 0x0C) removes the written bits from the pending word. The line drops only if the pending word becomes zero while enable is nonzero. Otherwise it keeps its value.
- R6: A write to the enable register (offset 0x04) stores the data and leaves the interrupt line unchanged. A read at 0x04 returns the stored enable word.
- R7: The pending word (offset 0x00) can be read but not written. A write there changes nothing and raises the error pulse.
- R8: Reads of the set and clear registers return zero.
- R9: Mailbox word i is read and written at offset 0x20 + 4*i, for i = 0 to 7. It is plain storage that changes only when it is written.
- R10: An access to any other offset is undecoded. This covers 0x10–0x1C, anything above 0x3C, and any offset with bits [1:0] nonzero. Such an access changes no state, reads as zero and raises the error pulse.
- R11: A read request produces rd_valid with its data one cycle later. A write produces no rd_valid. The error pulse appears in that same following cycle and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address; only bits [7:0] are decoded |
| req_wdata | input | 32 | Write data, little-endian (bit 0 is bit 0 of the register) |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| bad_access | output | 1 | One-cycle pulse for an undecoded access or a write to the pending word |
| irq | output | 1 | Level interrupt to the owning core |

## Verification
The checks assume that every request lasts exactly one cycle and that a single access never targets two registers at once. They also assume that reset is held for at least one clock edge before any access is made. The bench drives each access for one cycle from the falling edge and returns req_valid to low between accesses. Outputs are sampled on the falling edge after the capturing edge. The stimulus steers the interrupt rules through each branch in turn: a set write while enable is zero, an enable change while bits are pending, and a clear to zero while enable is zero and again while it is not. The stimulus also covers aliased high addresses, misaligned offsets and offsets just past the mailbox window.

// File: rtl/ipi_regs_pkg.sv
// Package: ipi_regs_pkg
// Shared register offsets and the access classification used by the
// per-core interprocessor interrupt register bank. Offsets are byte
// offsets inside the low address byte; all registers are 32-bit words.
package ipi_regs_pkg;

    localparam logic [7:0] OFF_PENDING = 8'h00;
    localparam logic [7:0] OFF_ENABLE  = 8'h04;
    localparam logic [7:0] OFF_SET     = 8'h08;
    localparam logic [7:0] OFF_CLEAR   = 8'h0C;
    localparam logic [7:0] MBOX_BASE   = 8'h20;

    // Which register an access targets.
    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_PENDING = 3'd1,
        ACC_ENABLE  = 3'd2,
        ACC_SET     = 3'd3,
        ACC_CLEAR   = 3'd4,
        ACC_MBOX    = 3'd5
    } acc_kind_e;

endpackage

// File: rtl/ipi_addr_decode.sv
// Module: ipi_addr_decode
// Purely combinational decode of the low address byte into a register
// class and a mailbox word index. Assumes the mailbox window
// (MBOX_BASE + 4*MBOX_WORDS) fits inside one byte of offset space and
// that MBOX_WORDS is a power of two of at least 2.
module ipi_addr_decode
    import ipi_regs_pkg::*;
#(
    parameter int MBOX_WORDS = 8,
    localparam int IDX_W     = $clog2(MBOX_WORDS)
) (
    input  logic [7:0]       offset,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] mbox_idx
);

    localparam int         MBOX_END_I = 32 + 4 * MBOX_WORDS;
    localparam logic [8:0] MBOX_END   = MBOX_END_I[8:0];

    logic [7:0] rel;
    logic       aligned;
    logic       in_mbox;

    // Offset relative to the start of the mailbox window.
    assign rel      = offset - MBOX_BASE;
    assign aligned  = (offset[1:0] == 2'b00);
    assign in_mbox  = aligned && (offset >= MBOX_BASE) && ({1'b0, offset} < MBOX_END);
    assign mbox_idx = rel[IDX_W+1:2];

    // Map the offset onto the register class it selects.
    always_comb begin
        kind = ACC_NONE;
        if (in_mbox) begin
            kind = ACC_MBOX;
        end else begin
            case (offset)
                OFF_PENDING: kind = ACC_PENDING;
                OFF_ENABLE:  kind = ACC_ENABLE;
                OFF_SET:     kind = ACC_SET;
                OFF_CLEAR:   kind = ACC_CLEAR;
                default:     kind = ACC_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ipi_status_ctrl.sv
// Module: ipi_status_ctrl
// Holds the pending word, the enable word and the interrupt line.
// Set strobes OR into pending and may raise the line; clear strobes
// remove bits and may lower it; an enable write never touches the line.
// Assumes at most one of the three strobes is active in a cycle.
module ipi_status_ctrl #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic          en_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] pending_o,
    output logic [DW-1:0] enable_o,
    output logic          irq_o
);

    logic [DW-1:0] pending_q;
    logic [DW-1:0] enable_q;
    logic          irq_q;
    logic [DW-1:0] pending_after_set;
    logic [DW-1:0] pending_after_clr;

    // Candidate pending values for the two strobe kinds.
    assign pending_after_set = pending_q | wdata;
    assign pending_after_clr = pending_q & ~wdata;

    // Pending word: changes only on set or clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else if (set_we) begin
            pending_q <= pending_after_set;
        end else if (clr_we) begin
            pending_q <= pending_after_clr;
        end
    end

    // Enable word: plain storage written by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (en_we) begin
            enable_q <= wdata;
        end
    end

    // Interrupt line: raised on a set, lowered on a clear, each with its own rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (set_we && ((pending_after_set & enable_q) != '0)) begin
            irq_q <= 1'b1;
        end else if (clr_we && (pending_after_clr == '0) && (enable_q != '0)) begin
            irq_q <= 1'b0;
        end
    end

    assign pending_o = pending_q;
    assign enable_o  = enable_q;
    assign irq_o     = irq_q;

    // R1: reset leaves the line low and the words clear.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_q && pending_q == '0 && enable_q == '0));

    // R7: pending changes only through set and clear strobes.
    p_pending_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(pending_q));

    // R6: without a set or clear strobe the line never moves.
    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(irq_q));

    // R3: an enabled pending bit after a set raises the line.
    p_set_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && (((pending_q | wdata) & enable_q) != '0)) |=> irq_q);

    // R4: a set that leaves nothing enabled keeps the line.
    p_set_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && (((pending_q | wdata) & enable_q) == '0)) |=> $stable(irq_q));

    // R5: a clear that does not empty pending, or runs with enable zero, keeps the line.
    p_clr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (((pending_q & ~wdata) != '0) || (enable_q == '0))) |=> $stable(irq_q));

    // R5: a clear that empties pending with enable nonzero drops the line.
    p_clr_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((pending_q & ~wdata) == '0) && (enable_q != '0)) |=> !irq_q);

endmodule

// File: rtl/ipi_mailbox.sv
// Module: ipi_mailbox
// A small array of mailbox words, each an independent register written
// by index. All words are exposed in parallel; the read mux sits in the
// parent. Assumes the index is in range whenever we is high.
module ipi_mailbox #(
    parameter int DW     = 32,
    parameter int WORDS  = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  logic [DW-1:0]             wdata,
    output logic [WORDS-1:0][DW-1:0]  words_o
);

    logic [WORDS-1:0][DW-1:0] words_q;

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        logic hit;
        // Word select for this slot.
        assign hit = we && (widx == IDX_W'(gi));

        // Mailbox word storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[gi] <= '0;
            end else if (hit) begin
                words_q[gi] <= wdata;
            end
        end
    end

    assign words_o = words_q;

    // R9: without a write strobe no mailbox word changes.
    p_mbox_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(words_q));

    // R1: reset clears every mailbox word.
    p_mbox_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (words_q == '0));

endmodule

// File: rtl/ipi_core_regs.sv
// Module: ipi_core_regs (top)
// Register bank one core owns for receiving interprocessor interrupts:
// pending, enable, set and clear registers plus a mailbox array, behind
// a one-request-per-cycle 32-bit register port with one-cycle read
// latency. Assumes each request lasts a single cycle.
module ipi_core_regs
    import ipi_regs_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DW         = 32,
    parameter int MBOX_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              bad_access,
    output logic              irq
);

    localparam int IDX_W = $clog2(MBOX_WORDS);

    acc_kind_e                     kind;
    logic [IDX_W-1:0]              mbox_idx;
    logic [DW-1:0]                 pending;
    logic [DW-1:0]                 enable;
    logic [MBOX_WORDS-1:0][DW-1:0] mbox_words;
    logic                          wr;
    logic                          rd;
    logic                          bad_now;
    logic [DW-1:0]                 rd_mux;
    logic                          rd_valid_q;
    logic [DW-1:0]                 rd_data_q;
    logic                          bad_q;
    logic                          unused_addr_hi;

    // Upper address bits do not take part in decode.
    assign unused_addr_hi = ^req_addr[ADDR_W-1:8];

    ipi_addr_decode #(
        .MBOX_WORDS (MBOX_WORDS)
    ) i_decode (
        .offset   (req_addr[7:0]),
        .kind     (kind),
        .mbox_idx (mbox_idx)
    );

    // Qualified read and write strobes.
    assign wr = req_valid && req_write;
    assign rd = req_valid && !req_write;

    ipi_status_ctrl #(
        .DW (DW)
    ) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (wr && (kind == ACC_SET)),
        .clr_we    (wr && (kind == ACC_CLEAR)),
        .en_we     (wr && (kind == ACC_ENABLE)),
        .wdata     (req_wdata),
        .pending_o (pending),
        .enable_o  (enable),
        .irq_o     (irq)
    );

    ipi_mailbox #(
        .DW    (DW),
        .WORDS (MBOX_WORDS)
    ) i_mbox (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr && (kind == ACC_MBOX)),
        .widx    (mbox_idx),
        .wdata   (req_wdata),
        .words_o (mbox_words)
    );

    // Error condition: undecoded offset, or a write to the read-only pending word.
    assign bad_now = req_valid && ((kind == ACC_NONE) || (req_write && (kind == ACC_PENDING)));

    // Read data select; strobe registers and holes read as zero.
    always_comb begin
        case (kind)
            ACC_PENDING: rd_mux = pending;
            ACC_ENABLE:  rd_mux = enable;
            ACC_MBOX:    rd_mux = mbox_words[mbox_idx];
            default:     rd_mux = '0;
        endcase
    end

    // Registered response: read valid, read data and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            bad_q      <= 1'b0;
        end else begin
            rd_valid_q <= rd;
            rd_data_q  <= rd ? rd_mux : '0;
            bad_q      <= bad_now;
        end
    end

    assign rd_valid   = rd_valid_q;
    assign rd_data    = rd_data_q;
    assign bad_access = bad_q;

    // R11: every read request yields rd_valid on the next cycle.
    p_read_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rd_valid);

    // R11: no request or a write yields no rd_valid.
    p_no_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rd_valid);

    // R10: an undecoded access pulses the error output.
    p_bad_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (kind == ACC_NONE)) |=> bad_access);

    // R10: an undecoded read returns zero.
    p_bad_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (kind == ACC_NONE)) |=> (rd_data == '0));

    // R8: strobe registers read back as zero.
    p_strobe_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ((kind == ACC_SET) || (kind == ACC_CLEAR))) |=> (rd_data == '0));

    // R7: writing the pending word leaves it unchanged.
    p_pending_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (kind == ACC_PENDING)) |=> $stable(pending));

endmodule

// File: tb/test_ipi_core_regs.sv
// Scoreboard bench for ipi_core_regs. A driver task issues accesses,
// updates a reference model built from the requirements and pushes the
// expected read data into a queue; a monitor pops and compares on rd_valid.
module test_ipi_core_regs;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        bad_access;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t rd_q[$];

    // Reference model state.
    logic [31:0] m_pend;
    logic [31:0] m_en;
    logic [31:0] m_mbox [8];
    logic        m_irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ipi_core_regs i_ipi_core_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .bad_access (bad_access),
        .irq        (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // 0 none, 1 pending, 2 enable, 3 set, 4 clear, 5 mailbox
    function automatic int kind_of(input logic [7:0] off);
        if (off[1:0] == 2'b00 && off >= 8'h20 && off <= 8'h3C) return 5;
        case (off)
            8'h00: return 1;
            8'h04: return 2;
            8'h08: return 3;
            8'h0C: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_pend = '0;
        m_en   = '0;
        m_irq  = 1'b0;
        for (int i = 0; i < 8; i++) m_mbox[i] = '0;
    endtask

    // Monitor: compare each returned read against the queued expectation (R11 ordering).
    always @(negedge clk) begin
        if (rd_valid) begin
            if (rd_q.size() == 0) begin
                chk(1'b0, "R11 unexpected rd_valid", 32'h1, 32'h0);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                chk(rd_data === it.exp, it.tag, rd_data, it.exp);
            end
        end
    end

    // Driver: one single-cycle access, model update and response checks.
    task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d, input string tag);
        int          k;
        bit          exp_bad;
        logic [31:0] exp_rd;
        k = kind_of(a[7:0]);
        exp_bad = (k == 0) || (wr && k == 1);
        exp_rd  = '0;
        case (k)
            1: exp_rd = m_pend;
            2: exp_rd = m_en;
            5: exp_rd = m_mbox[(a[7:0] - 8'h20) >> 2];
            default: exp_rd = '0;
        endcase
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        if (!wr) rd_q.push_back('{exp_rd, tag});
        if (wr) begin
            case (k)
                2: m_en = d;
                3: begin
                    m_pend = m_pend | d;
                    if ((m_pend & m_en) != 0) m_irq = 1'b1;
                end
                4: begin
                    m_pend = m_pend & ~d;
                    if (m_pend == 0 && m_en != 0) m_irq = 1'b0;
                end
                5: m_mbox[(a[7:0] - 8'h20) >> 2] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        chk(bad_access === exp_bad, {tag, " bad_access"}, {31'd0, bad_access}, {31'd0, exp_bad});
        chk(irq === m_irq, {tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
        chk(rd_valid === !wr, {"R11 rd_valid after ", tag}, {31'd0, rd_valid}, {31'd0, !wr});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        chk(irq === 1'b0, "R1 irq in reset", {31'd0, irq}, 32'd0);
        chk(rd_valid === 1'b0, "R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
        chk(bad_access === 1'b0, "R1 bad_access in reset", {31'd0, bad_access}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic read_all(input string tag);
        access(0, 12'h000, '0, {tag, " pending"});
        access(0, 12'h004, '0, {tag, " enable"});
        for (int i = 0; i < 8; i++) access(0, 12'(8'h20 + 4 * i), '0, {tag, " mailbox"});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        read_all("R1 after reset");

        // R4: set with enable zero leaves irq low.
        access(1, 12'h008, 32'h0000_0005, "R4 set with enable zero");
        access(0, 12'h000, '0, "R3 pending ORed");
        // R6: enable covering a pending bit does not raise irq.
        access(1, 12'h004, 32'h0000_0001, "R6 enable write irq held");
        access(0, 12'h004, '0, "R6 enable readback");
        // R3: set of zero re-evaluates and raises.
        access(1, 12'h008, 32'h0000_0000, "R3 set raises irq");
        // R5: partial clear keeps irq high.
        access(1, 12'h00C, 32'h0000_0001, "R5 partial clear keeps irq");
        access(0, 12'h000, '0, "R5 pending after clear");
        // R6: enable to zero leaves irq high.
        access(1, 12'h004, 32'h0000_0000, "R6 enable zero irq held");
        // R5: clear to zero with enable zero keeps irq high.
        access(1, 12'h00C, 32'h0000_0004, "R5 clear with enable zero");
        access(1, 12'h004, 32'h0000_0008, "R6 enable nonzero irq held");
        // R5: clear of nothing with pending zero and enable nonzero drops irq.
        access(1, 12'h00C, 32'h0000_0000, "R5 clear drops irq");
        // R4: set of a masked bit keeps irq low.
        access(1, 12'h008, 32'h8000_0000, "R4 masked set");
        access(1, 12'h008, 32'h0000_0008, "R3 enabled set");
        // R8: set and clear read zero.
        access(0, 12'h008, '0, "R8 set reads zero");
        access(0, 12'h00C, '0, "R8 clear reads zero");
        // R7: pending write ignored.
        access(1, 12'h000, 32'hFFFF_FFFF, "R7 pending write ignored");
        access(0, 12'h000, '0, "R7 pending unchanged");
        access(1, 12'h00C, 32'hFFFF_FFFF, "R5 clear all");
        // R2: aliased address.
        access(1, 12'h104, 32'hA5A5_0F0F, "R2 alias enable write");
        access(0, 12'h004, '0, "R2 alias readback");
        access(0, 12'hF04, '0, "R2 alias read high");

        // R9: mailbox words.
        for (int i = 0; i < 8; i++)
            access(1, 12'(8'h20 + 4 * i), 32'h1000_0001 * (i + 1) ^ 32'hC3C3_0000, "R9 mailbox write");
        for (int i = 7; i >= 0; i--)
            access(0, 12'(8'h20 + 4 * i), '0, "R9 mailbox read");
        access(0, 12'h93C, '0, "R2 R9 aliased mailbox read");

        // R10: undecoded offsets.
        access(1, 12'h010, 32'hDEAD_BEEF, "R10 write hole 0x10");
        access(1, 12'h040, 32'hDEAD_BEEF, "R10 write past mailbox");
        access(1, 12'h022, 32'hDEAD_BEEF, "R10 misaligned write");
        access(1, 12'h005, 32'h0000_0000, "R10 misaligned enable");
        access(0, 12'h020, '0, "R10 mailbox untouched");
        access(0, 12'h004, '0, "R10 enable untouched");
        access(0, 12'h01C, '0, "R10 read hole");
        access(0, 12'h0FC, '0, "R10 read top");
        access(0, 12'h03E, '0, "R10 misaligned read");

        // R1: reset in mid-run.
        access(1, 12'h008, 32'h0000_0001, "R3 set before reset");
        do_reset();
        read_all("R1 after second reset");

        @(negedge clk);
        chk(rd_q.size() == 0, "R11 all reads returned", rd_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule